// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block tracks how many video lines have been rendered in the current frame and raises a level interrupt once a programmable line count is reached. A video timing source presents a dot position and a line number, qualified by a valid strobe, together with a flag that says whether rendering is on. The block evaluates its state once per line, at one fixed dot. On the first rendered line of a frame it sets an in-frame flag. On each rendered line after that it advances a line counter, and it latches a pending flag when the counter matches the programmed target.

Software reaches the block through a small synchronous register bus. Address 0 holds the 8-bit target line count. Address 1 takes the interrupt enable on writes. A read of address 1 returns a status byte, and that read also clears the pending flag. The interrupt output combines the gated pending flag with an auxiliary interrupt request from a neighbouring block. If rendering stops, either because it is switched off or because the frame has moved past its visible lines, the frame state is dropped.

Top module: `scanirq_unit`

## Requirements
- R1: After reset the target is 0, the enable is off, the in-frame and pending flags are clear, a status read returns 0x00, a target read returns 0x00, and `irq` is low while `aux_irq` is low.
- R2: Frame state changes only in a cycle where `vid_valid` is high and `dot` equals 336. Any other dot, or `vid_valid` low, has no effect.
- R3: In a sample cycle the prepared line is `line`+1. If `render_en` is low, or the prepared line is 241 or greater, the in-frame flag, the counter and the pending flag are all cleared. A prepared line of 240 still counts as rendered.
- R4: A valid sample cycle with the in-frame flag clear sets the in-frame flag, loads the counter with 0 and clears pending. No target compare takes place on that line, so a target of 0 does not fire.
- R5: Each later valid sample cycle increments the counter by one. Pending is set when the incremented value equals the target.
- R6: A write to address 0 stores all 8 data bits as the target. A read of address 0 returns the stored target.
- R7: A write to address 1 sets the enable from data bit 7. Bits 6..0 of that write are ignored.
- R8: A read of address 1 returns pending in bit 7, in-frame in bit 6 and zero in bits 5..0, and clears pending at the end of that cycle. If a compare match sets pending in the same cycle, the set wins, and the read returns the value from before the set.
- R9: `irq` is high exactly when (pending AND enable) OR `aux_irq`.
- R10: A pending flag set while the enable is off stays latched, and `irq` rises in the cycle after enable is written to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_valid | input | 1 | Video timing position valid |
| dot | input | 9 | Current dot within the line |
| line | input | 9 | Current line number |
| render_en | input | 1 | Rendering enabled |
| aux_irq | input | 1 | Auxiliary interrupt request merged into irq |
| bus_addr | input | 2 | Register address (0 target, 1 control/status) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle the read strobe is high |
| irq | output | 1 | Level interrupt output |

## Verification
The counter is driven with sample strobes at the chosen dot, at a neighbouring dot, and with the strobe deasserted. This separates the dot decode from the valid qualification. Frames are started with target values of 0, 1, 2 and 3. These runs show that the start line does no compare and that the match lands on the correct line. They also include the case where a match and a status read arrive in the same cycle. The frame is stopped both by turning rendering off and by reaching prepared line 241, with line 239 used to show that prepared line 240 still counts. The interrupt output is observed with enable on and off, with a disabled write that has only the low bits set, and with the auxiliary input.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_TARGET = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = ADDR_W'(1);

    localparam int STAT_PEND_BIT  = 7;
    localparam int STAT_FRAME_BIT = 6;
    localparam int CTRL_EN_BIT    = 7;

    typedef struct packed {
        logic              in_frame;
        logic [DATA_W-1:0] count;
        logic              pending;
    } line_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] target;
        logic              enable;
    } cfg_state_t;
endpackage

// File: rtl/scanirq_tick.sv
module scanirq_tick #(
    parameter int DOT_W      = 9,
    parameter int LINE_W     = 9,
    parameter int SAMPLE_DOT = 336,
    parameter int STOP_LINE  = 241
) (
    input  logic              vid_valid,
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    input  logic              render_en,
    output logic              tick,
    output logic              line_ok
);
    localparam int PREP_W = LINE_W + 1;

    logic [PREP_W-1:0] prep_line;

    always_comb begin
        prep_line = {1'b0, line} + PREP_W'(1);
        tick      = vid_valid && (dot == DOT_W'(SAMPLE_DOT));
        line_ok   = render_en && (prep_line < PREP_W'(STOP_LINE));
    end
endmodule

// File: rtl/scanirq_regs.sv
module scanirq_regs
    import scanirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              pending,
    input  logic              in_frame,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] target,
    output logic              enable,
    output logic              stat_rd
);
    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr && bus_addr == ADDR_TARGET) cfg_d.target = bus_wdata;
        if (bus_wr && bus_addr == ADDR_CTRL)   cfg_d.enable = bus_wdata[CTRL_EN_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        bus_rdata = '0;
        stat_rd   = bus_rd && (bus_addr == ADDR_CTRL);
        if (bus_rd && bus_addr == ADDR_TARGET) bus_rdata = cfg_q.target;
        if (stat_rd) begin
            bus_rdata[STAT_PEND_BIT]  = pending;
            bus_rdata[STAT_FRAME_BIT] = in_frame;
        end
        target = cfg_q.target;
        enable = cfg_q.enable;
    end

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(cfg_q));

    // R8
    stat_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> bus_rdata[5:0] == 6'd0);
endmodule

// File: rtl/scanirq_linectr.sv
module scanirq_linectr
    import scanirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_ok,
    input  logic              stat_rd,
    input  logic [DATA_W-1:0] target,
    output logic              in_frame,
    output logic              pending
);
    line_state_t       st_d, st_q;
    logic [DATA_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = st_q.count + DATA_W'(1);
        st_d    = st_q;
        if (stat_rd) st_d.pending = 1'b0;
        if (tick) begin
            if (!line_ok) begin
                st_d = '0;
            end else if (!st_q.in_frame) begin
                st_d.in_frame = 1'b1;
                st_d.count    = '0;
                st_d.pending  = 1'b0;
            end else begin
                st_d.count = cnt_inc;
                if (cnt_inc == target) st_d.pending = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_frame = st_q.in_frame;
    assign pending  = st_q.pending;

    // R3
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !line_ok |=> !st_q.in_frame && !st_q.pending && st_q.count == '0);

    // R4
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && line_ok && !st_q.in_frame |=> st_q.in_frame && !st_q.pending && st_q.count == '0);

    // R2
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.count) && $stable(st_q.in_frame));

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !tick |=> !st_q.pending);
endmodule

// File: rtl/scanirq_unit.sv
module scanirq_unit
    import scanirq_pkg::*;
#(
    parameter int DOT_W      = 9,
    parameter int LINE_W     = 9,
    parameter int SAMPLE_DOT = 336,
    parameter int STOP_LINE  = 241
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_valid,
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    input  logic              render_en,
    input  logic              aux_irq,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              tick, line_ok, stat_rd, enable, pending, in_frame;
    logic [DATA_W-1:0] target;

    scanirq_tick #(
        .DOT_W(DOT_W), .LINE_W(LINE_W),
        .SAMPLE_DOT(SAMPLE_DOT), .STOP_LINE(STOP_LINE)
    ) u_tick (
        .vid_valid(vid_valid), .dot(dot), .line(line), .render_en(render_en),
        .tick(tick), .line_ok(line_ok)
    );

    scanirq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .pending(pending),
        .in_frame(in_frame), .bus_rdata(bus_rdata), .target(target),
        .enable(enable), .stat_rd(stat_rd)
    );

    scanirq_linectr u_ctr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_ok(line_ok),
        .stat_rd(stat_rd), .target(target), .in_frame(in_frame), .pending(pending)
    );

    assign irq = (pending && enable) || aux_irq;

    // R9
    aux_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_irq |-> irq);

    // R10
    late_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) && pending |-> irq);

    // R9
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pending && !aux_irq |-> !irq);
endmodule

// File: tb/scanirq_unit_tb.sv
module scanirq_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vid_valid = 1'b0;
    logic [8:0] dot = '0;
    logic [8:0] line = '0;
    logic       render_en = 1'b0;
    logic       aux_irq = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    scanirq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .dot(dot), .line(line),
        .render_en(render_en), .aux_irq(aux_irq), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: compares every read against the scoreboard queue
    initial begin
        forever begin
            logic [7:0] e;
            string      t;
            @(negedge clk);
            #1;
            if (bus_rd) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected read rdata=%h expected=none", bus_rdata);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (bus_rdata !== e) begin
                        errors++;
                        $display("FAIL %s rdata=%h expected=%h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic line_evt(input logic v, input logic [8:0] d, input logic [8:0] ln,
                            input logic ren);
        @(negedge clk);
        vid_valid = v; dot = d; line = ln; render_en = ren;
        @(negedge clk);
        vid_valid = 1'b0;
    endtask

    task automatic evt_and_read(input logic [8:0] ln, input logic [7:0] e, input string t);
        @(negedge clk);
        vid_valid = 1'b1; dot = 9'd336; line = ln; render_en = 1'b1;
        bus_addr = 2'd1; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        vid_valid = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string t);
        @(negedge clk);
        #1;
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq=%b expected=%b", t, irq, e);
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_read(2'd1, 8'h00, "R1 status after reset");
        bus_read(2'd0, 8'h00, "R1 target after reset");
        check_irq(1'b0, "R1 irq after reset");
        // R6 full byte target
        bus_write(2'd0, 8'hA5);
        bus_read(2'd0, 8'hA5, "R6 target readback");
        bus_write(2'd0, 8'h00);
        // R2 wrong dot and no valid do nothing
        line_evt(1'b1, 9'd335, 9'd0, 1'b1);
        bus_read(2'd1, 8'h00, "R2 dot 335 ignored");
        line_evt(1'b0, 9'd336, 9'd0, 1'b1);
        bus_read(2'd1, 8'h00, "R2 valid low ignored");
        // R4 frame start, target 0 does not fire
        line_evt(1'b1, 9'd336, 9'd0, 1'b1);
        bus_read(2'd1, 8'h40, "R4 start no compare");
        // R5 count to target 3
        bus_write(2'd0, 8'd3);
        line_evt(1'b1, 9'd336, 9'd1, 1'b1);
        line_evt(1'b1, 9'd336, 9'd2, 1'b1);
        bus_read(2'd1, 8'h40, "R5 before match");
        line_evt(1'b1, 9'd336, 9'd3, 1'b1);
        check_irq(1'b0, "R10 pending while disabled");
        bus_write(2'd1, 8'h80);
        check_irq(1'b1, "R10 irq after late enable");
        bus_read(2'd1, 8'hC0, "R5 R8 pending set");
        check_irq(1'b0, "R8 irq drops after status read");
        bus_read(2'd1, 8'h40, "R8 pending cleared by read");
        bus_write(2'd1, 8'h00);
        // R3 render off drops frame
        line_evt(1'b1, 9'd336, 9'd10, 1'b0);
        bus_read(2'd1, 8'h00, "R3 render off clears");
        // R7 enable uses only bit 7
        bus_write(2'd0, 8'd2);
        line_evt(1'b1, 9'd336, 9'd0, 1'b1);
        line_evt(1'b1, 9'd336, 9'd1, 1'b1);
        line_evt(1'b1, 9'd336, 9'd2, 1'b1);
        bus_write(2'd1, 8'h7F);
        check_irq(1'b0, "R7 low bits do not enable");
        bus_write(2'd1, 8'h80);
        check_irq(1'b1, "R9 pending and enabled");
        bus_write(2'd1, 8'h00);
        check_irq(1'b0, "R9 disabled");
        @(negedge clk); aux_irq = 1'b1;
        check_irq(1'b1, "R9 aux merged");
        @(negedge clk); aux_irq = 1'b0;
        // R3 prepared 240 rendered, 241 stops
        line_evt(1'b1, 9'd336, 9'd239, 1'b1);
        bus_read(2'd1, 8'hC0, "R3 prepared 240 in frame");
        line_evt(1'b1, 9'd336, 9'd240, 1'b1);
        bus_read(2'd1, 8'h00, "R3 prepared 241 clears");
        // R8 set wins over same-cycle read
        bus_write(2'd0, 8'd1);
        line_evt(1'b1, 9'd336, 9'd0, 1'b1);
        evt_and_read(9'd1, 8'h40, "R8 read during match");
        bus_read(2'd1, 8'hC0, "R8 set wins over clear");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule